// File: doc/BRIEF.md
# Program-Order Store Buffer

This block holds stores that have been decoded but have not yet been written to memory, in the order the program issued them, inside a circular array of entries. The decode stage asks for an entry and receives a tag. The low bits of the tag are the entry index, and the top bit is a wrap marker. Later, the execution stages record the store's address and its data into that entry through two separate write ports. Each write names the entry index, so the address and the data may arrive in any order, for any entry. The retire logic marks an entry as allowed to commit through a third port.

The oldest entry is offered to a memory write port once its address, its data and its commit permission are all present. It is released when the memory side accepts the write. Younger entries never go out ahead of it.

Loads look into the buffer with their address and with the tag that was current when the load was decoded. That tag marks which stores are older than the load. The search walks the older stores from youngest to oldest and stops at the first store that either has an unknown address or has the same address.
- If that store's address matches and its data is present, the data is forwarded.
- If its address is unknown, or its data is missing, the answer is "unknown".
- If the search finds no such store, the load must read memory.

Top module: `pstore_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_ok` is 1, `alloc_tag` is 0, `mem_wr_valid` is 0, and both `ld_fwd` and `ld_unk` are 0.
- R2: Each accepted allocation (`alloc_req` and `alloc_ok` both high at a clock edge) takes the entry whose index is `alloc_tag[IDXW-1:0]`. It then advances `alloc_tag` by exactly one, modulo 2·DEPTH. Without an accepted allocation, `alloc_tag` holds.
- R3: With DEPTH entries occupied, `alloc_ok` is 0, and a request is not accepted: `alloc_tag` does not move.
- R4: `mem_wr_valid` is 1 only when the oldest entry has its address recorded, its data recorded and its commit permission set. A younger entry that is complete does not raise it.
- R5: Memory writes leave in allocation order. `mem_wr_addr` and `mem_wr_data` are those of the oldest entry.
- R6: The oldest entry is freed at the edge where `mem_wr_valid` and `mem_wr_ready` are both 1. While `mem_wr_ready` is 0, `mem_wr_valid`, `mem_wr_addr` and `mem_wr_data` hold. Freeing an entry makes room for a new allocation.
- R7: A lookup returns `ld_fwd`=1 and the data of the youngest store older than the load whose address equals `ld_addr`, provided that store's data is recorded and no younger older store has an unknown address.
- R8: Stores allocated at or after the load's tag `ld_tag` are ignored by the lookup, and so are stores already drained.
- R9: `ld_unk`=1 (with `ld_fwd`=0) when the youngest older store that has an unknown address or a matching address either has an unknown address, or matches but has no data yet.
- R10: When no older store matches and none has an unknown address, `ld_fwd` and `ld_unk` are both 0.
- R11: Address, data and commit writes that name an entry not currently allocated are ignored. A later allocation of that entry starts with nothing recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_req | input | 1 | Decode asks for an entry |
| alloc_ok | output | 1 | An entry is free |
| alloc_tag | output | IDXW+1 | Tag given to the next allocation; low bits are the index |
| addr_we | input | 1 | Record an address |
| addr_idx | input | IDXW | Entry receiving the address |
| addr_val | input | AW | Store address |
| data_we | input | 1 | Record store data |
| data_idx | input | IDXW | Entry receiving the data |
| data_val | input | DW | Store data |
| cmt_we | input | 1 | Grant commit permission |
| cmt_idx | input | IDXW | Entry being granted |
| mem_wr_valid | output | 1 | Oldest entry ready to write memory |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | AW | Address of the oldest entry |
| mem_wr_data | output | DW | Data of the oldest entry |
| ld_addr | input | AW | Load address to search |
| ld_tag | input | IDXW+1 | Allocation tag current when the load was decoded |
| ld_fwd | output | 1 | Data forwarded from a store |
| ld_unk | output | 1 | Outcome cannot be decided yet |
| ld_data | output | DW | Forwarded data |

## Verification
The bound checker keeps its own count of occupied entries from the two handshakes, and checks the following on every cycle:
- no allocation is accepted when the buffer is full, and nothing is offered to memory when it is empty;
- the tag moves by exactly one per accepted allocation;
- a stalled memory write holds its address and data;
- forward and unknown are never raised together.

Which stores a lookup treats as older, youngest-first selection, unknown-address blocking, in-order draining past a complete younger entry, and ignored writes to free entries depend on the stored contents. Only the bench's scenarios can show them, including lookups across the index wrap.

// File: rtl/pstore_pkg.sv
package pstore_pkg;
   // Per-entry state bits: allocated, address known, data known, commit granted
   typedef struct packed {
      logic vld;
      logic av;
      logic dv;
      logic cm;
   } sb_flags_t;
endpackage

// File: rtl/pstore_ptrs.sv
module pstore_ptrs #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned PTRW  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            alloc_fire,
   input  logic            drain_fire,
   output logic [PTRW-1:0] head_ptr,
   output logic [PTRW-1:0] tail_ptr,
   output logic [PTRW-1:0] count,
   output logic            full
);
   logic [PTRW-1:0] head_q, tail_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
      end else begin
         if (alloc_fire) tail_q <= tail_q + PTRW'(1);
         if (drain_fire) head_q <= head_q + PTRW'(1);
      end
   end

   assign head_ptr = head_q;
   assign tail_ptr = tail_q;
   assign count    = tail_q - head_q;
   assign full     = (count == PTRW'(DEPTH));
endmodule

// File: rtl/pstore_entries.sv
module pstore_entries
   import pstore_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned IDXW  = 3,
   parameter int unsigned AW    = 16,
   parameter int unsigned DW    = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            alloc_fire,
   input  logic [IDXW-1:0] alloc_idx,
   input  logic            addr_we,
   input  logic [IDXW-1:0] addr_idx,
   input  logic [AW-1:0]   addr_val,
   input  logic            data_we,
   input  logic [IDXW-1:0] data_idx,
   input  logic [DW-1:0]   data_val,
   input  logic            cmt_we,
   input  logic [IDXW-1:0] cmt_idx,
   input  logic            drain_fire,
   input  logic [IDXW-1:0] drain_idx,
   output sb_flags_t       flags_o [DEPTH],
   output logic [AW-1:0]   addr_o  [DEPTH],
   output logic [DW-1:0]   data_o  [DEPTH]
);
   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic          vld_q, av_q, dv_q, cm_q;
      logic [AW-1:0] a_q;
      logic [DW-1:0] d_q;
      logic          hit_alloc, hit_drain, hit_a, hit_d, hit_c;

      assign hit_alloc = alloc_fire && (alloc_idx == IDXW'(e));
      assign hit_drain = drain_fire && (drain_idx == IDXW'(e));
      assign hit_a     = addr_we && (addr_idx == IDXW'(e)) && vld_q;
      assign hit_d     = data_we && (data_idx == IDXW'(e)) && vld_q;
      assign hit_c     = cmt_we  && (cmt_idx  == IDXW'(e)) && vld_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            av_q  <= 1'b0;
            dv_q  <= 1'b0;
            cm_q  <= 1'b0;
         end else if (hit_alloc) begin
            vld_q <= 1'b1;
            av_q  <= 1'b0;
            dv_q  <= 1'b0;
            cm_q  <= 1'b0;
         end else if (hit_drain) begin
            vld_q <= 1'b0;
            av_q  <= 1'b0;
            dv_q  <= 1'b0;
            cm_q  <= 1'b0;
         end else begin
            if (hit_a) av_q <= 1'b1;
            if (hit_d) dv_q <= 1'b1;
            if (hit_c) cm_q <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (hit_a) a_q <= addr_val;
         if (hit_d) d_q <= data_val;
      end

      assign flags_o[e] = '{vld: vld_q, av: av_q, dv: dv_q, cm: cm_q};
      assign addr_o[e]  = a_q;
      assign data_o[e]  = d_q;
   end
endmodule

// File: rtl/pstore_fwd.sv
module pstore_fwd
   import pstore_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned IDXW  = 3,
   parameter int unsigned PTRW  = 4,
   parameter int unsigned AW    = 16,
   parameter int unsigned DW    = 32
) (
   input  sb_flags_t       flags_i [DEPTH],
   input  logic [AW-1:0]   addr_i  [DEPTH],
   input  logic [DW-1:0]   data_i  [DEPTH],
   input  logic [PTRW-1:0] head_ptr,
   input  logic [PTRW-1:0] count,
   input  logic [AW-1:0]   ld_addr,
   input  logic [PTRW-1:0] ld_tag,
   output logic            ld_fwd,
   output logic            ld_unk,
   output logic [DW-1:0]   ld_data
);
   logic [PTRW-1:0] span, n_old;
   logic [IDXW-1:0] slot;

   // Stores older than the load are the first n_old positions from the head.
   // A tag already passed by the head gives a span above the occupancy.
   assign span  = ld_tag - head_ptr;
   assign n_old = (span > count) ? '0 : span;

   // Walk oldest to youngest; a later (younger) candidate overrides.
   always_comb begin
      ld_fwd  = 1'b0;
      ld_unk  = 1'b0;
      ld_data = '0;
      slot    = '0;
      for (int k = 0; k < DEPTH; k++) begin
         slot = head_ptr[IDXW-1:0] + IDXW'(k);
         if ((PTRW'(k) < n_old) && flags_i[slot].vld) begin
            if (!flags_i[slot].av) begin
               ld_fwd  = 1'b0;
               ld_unk  = 1'b1;
               ld_data = '0;
            end else if (addr_i[slot] == ld_addr) begin
               if (flags_i[slot].dv) begin
                  ld_fwd  = 1'b1;
                  ld_unk  = 1'b0;
                  ld_data = data_i[slot];
               end else begin
                  ld_fwd  = 1'b0;
                  ld_unk  = 1'b1;
                  ld_data = '0;
               end
            end
         end
      end
   end
endmodule

// File: rtl/pstore_buf.sv
module pstore_buf
   import pstore_pkg::*;
#(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned AW    = 16,
   parameter int unsigned DW    = 32,
   localparam int unsigned IDXW = $clog2(DEPTH),
   localparam int unsigned PTRW = IDXW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            alloc_req,
   output logic            alloc_ok,
   output logic [PTRW-1:0] alloc_tag,
   input  logic            addr_we,
   input  logic [IDXW-1:0] addr_idx,
   input  logic [AW-1:0]   addr_val,
   input  logic            data_we,
   input  logic [IDXW-1:0] data_idx,
   input  logic [DW-1:0]   data_val,
   input  logic            cmt_we,
   input  logic [IDXW-1:0] cmt_idx,
   output logic            mem_wr_valid,
   input  logic            mem_wr_ready,
   output logic [AW-1:0]   mem_wr_addr,
   output logic [DW-1:0]   mem_wr_data,
   input  logic [AW-1:0]   ld_addr,
   input  logic [PTRW-1:0] ld_tag,
   output logic            ld_fwd,
   output logic            ld_unk,
   output logic [DW-1:0]   ld_data
);
   // Elaboration-time parameter checks
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pstore_buf: DEPTH must be a power of two of at least 2");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("pstore_buf: AW and DW must be positive");
   end

   logic            alloc_fire, drain_fire, full;
   logic [PTRW-1:0] head_ptr, tail_ptr, count;
   logic [IDXW-1:0] head_idx;
   sb_flags_t       flags [DEPTH];
   logic [AW-1:0]   addrs [DEPTH];
   logic [DW-1:0]   datas [DEPTH];

   assign alloc_ok   = !full;
   assign alloc_fire = alloc_req && !full;
   assign alloc_tag  = tail_ptr;
   assign head_idx   = head_ptr[IDXW-1:0];

   pstore_ptrs #(.DEPTH(DEPTH), .PTRW(PTRW)) u_ptrs (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_fire (alloc_fire),
      .drain_fire (drain_fire),
      .head_ptr   (head_ptr),
      .tail_ptr   (tail_ptr),
      .count      (count),
      .full       (full)
   );

   pstore_entries #(.DEPTH(DEPTH), .IDXW(IDXW), .AW(AW), .DW(DW)) u_ent (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_fire (alloc_fire),
      .alloc_idx  (tail_ptr[IDXW-1:0]),
      .addr_we    (addr_we),
      .addr_idx   (addr_idx),
      .addr_val   (addr_val),
      .data_we    (data_we),
      .data_idx   (data_idx),
      .data_val   (data_val),
      .cmt_we     (cmt_we),
      .cmt_idx    (cmt_idx),
      .drain_fire (drain_fire),
      .drain_idx  (head_idx),
      .flags_o    (flags),
      .addr_o     (addrs),
      .data_o     (datas)
   );

   // Head drains only with address, data and commit permission all present
   assign mem_wr_valid = flags[head_idx].vld && flags[head_idx].av &&
                         flags[head_idx].dv  && flags[head_idx].cm;
   assign mem_wr_addr  = addrs[head_idx];
   assign mem_wr_data  = datas[head_idx];
   assign drain_fire   = mem_wr_valid && mem_wr_ready;

   pstore_fwd #(.DEPTH(DEPTH), .IDXW(IDXW), .PTRW(PTRW), .AW(AW), .DW(DW)) u_fwd (
      .flags_i  (flags),
      .addr_i   (addrs),
      .data_i   (datas),
      .head_ptr (head_ptr),
      .count    (count),
      .ld_addr  (ld_addr),
      .ld_tag   (ld_tag),
      .ld_fwd   (ld_fwd),
      .ld_unk   (ld_unk),
      .ld_data  (ld_data)
   );
endmodule

// File: rtl/pstore_chk.sv
module pstore_chk #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned AW    = 16,
   parameter int unsigned DW    = 32,
   localparam int unsigned PTRW = $clog2(DEPTH) + 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            alloc_req,
   input logic            alloc_ok,
   input logic [PTRW-1:0] alloc_tag,
   input logic            mem_wr_valid,
   input logic            mem_wr_ready,
   input logic [AW-1:0]   mem_wr_addr,
   input logic [DW-1:0]   mem_wr_data,
   input logic            ld_fwd,
   input logic            ld_unk
);
   logic            acc, drn;
   logic [PTRW-1:0] occ;

   assign acc = alloc_req && alloc_ok;
   assign drn = mem_wr_valid && mem_wr_ready;

   // Independent occupancy model built from the handshakes only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= '0;
      else        occ <= occ + PTRW'(acc) - PTRW'(drn);
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == PTRW'(DEPTH)) |-> !alloc_ok); // R3
   AST_EMPTY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0) |-> !mem_wr_valid); // R4
   AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (alloc_tag == $past(alloc_tag) + PTRW'(1))); // R2
   AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> $stable(alloc_tag)); // R2
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && !mem_wr_ready) |=>
         (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data))); // R6
   AST_LD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_fwd && ld_unk)); // R9
endmodule

bind pstore_buf pstore_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .alloc_req    (alloc_req),
   .alloc_ok     (alloc_ok),
   .alloc_tag    (alloc_tag),
   .mem_wr_valid (mem_wr_valid),
   .mem_wr_ready (mem_wr_ready),
   .mem_wr_addr  (mem_wr_addr),
   .mem_wr_data  (mem_wr_data),
   .ld_fwd       (ld_fwd),
   .ld_unk       (ld_unk)
);

// File: tb/pstore_buf_tb.sv
`timescale 1ns/1ps
module pstore_buf_tb;
   localparam int DEPTH = 8;
   localparam int AW    = 16;
   localparam int DW    = 32;
   localparam int IDXW  = 3;
   localparam int PTRW  = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            alloc_req = 1'b0, alloc_ok;
   logic [PTRW-1:0] alloc_tag;
   logic            addr_we = 1'b0, data_we = 1'b0, cmt_we = 1'b0;
   logic [IDXW-1:0] addr_idx = '0, data_idx = '0, cmt_idx = '0;
   logic [AW-1:0]   addr_val = '0, ld_addr = '0, mem_wr_addr;
   logic [DW-1:0]   data_val = '0, mem_wr_data, ld_data;
   logic            mem_wr_valid, mem_wr_ready = 1'b0;
   logic [PTRW-1:0] ld_tag = '0;
   logic            ld_fwd, ld_unk;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk; // 125 MHz

   pstore_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (.*);

   typedef struct packed {
      logic [AW-1:0]   a;
      logic [PTRW-1:0] tag;
      logic            fwd;
      logic            unk;
      logic [DW-1:0]   d;
   } ld_vec_t;

   // Stores present: S0 0x100/A0, S1 0x200/B1, S2 0x100/C2, S3 ?/D3, S4 0x300/no data
   localparam ld_vec_t LD_TAB [9] = '{
      '{16'h0100, 4'd5, 1'b0, 1'b1, 32'h0},    // R9 unknown S3 younger than S2
      '{16'h0100, 4'd3, 1'b1, 1'b0, 32'hC2},   // R7 youngest of S0/S2
      '{16'h0100, 4'd2, 1'b1, 1'b0, 32'hA0},   // R7 only S0 older
      '{16'h0200, 4'd3, 1'b1, 1'b0, 32'hB1},   // R7
      '{16'h0300, 4'd5, 1'b0, 1'b1, 32'h0},    // R9 match without data
      '{16'h0400, 4'd3, 1'b0, 1'b0, 32'h0},    // R10 miss
      '{16'h0100, 4'd0, 1'b0, 1'b0, 32'h0},    // R8 no older store
      '{16'h0200, 4'd1, 1'b0, 1'b0, 32'h0},    // R8 S1 is younger
      '{16'h0300, 4'd4, 1'b0, 1'b1, 32'h0}     // R9 S3 unknown
   };

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_alloc();
      @(negedge clk) alloc_req = 1'b1;
      @(negedge clk) alloc_req = 1'b0;
   endtask

   task automatic put_addr(logic [IDXW-1:0] i, logic [AW-1:0] a);
      @(negedge clk) begin addr_we = 1'b1; addr_idx = i; addr_val = a; end
      @(negedge clk) addr_we = 1'b0;
   endtask

   task automatic put_data(logic [IDXW-1:0] i, logic [DW-1:0] d);
      @(negedge clk) begin data_we = 1'b1; data_idx = i; data_val = d; end
      @(negedge clk) data_we = 1'b0;
   endtask

   task automatic put_cmt(logic [IDXW-1:0] i);
      @(negedge clk) begin cmt_we = 1'b1; cmt_idx = i; end
      @(negedge clk) cmt_we = 1'b0;
   endtask

   task automatic pulse_ready();
      @(negedge clk) mem_wr_ready = 1'b1;
      @(negedge clk) mem_wr_ready = 1'b0;
   endtask

   task automatic look(string req, logic [AW-1:0] a, logic [PTRW-1:0] t,
                       logic f, logic u, logic [DW-1:0] d);
      @(negedge clk) begin ld_addr = a; ld_tag = t; end
      #1;
      chk({req, " fwd"}, 64'(ld_fwd), 64'(f));
      chk({req, " unk"}, 64'(ld_unk), 64'(u));
      if (f) chk({req, " data"}, 64'(ld_data), 64'(d));
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 alloc_ok", 64'(alloc_ok), 64'd1);
      chk("R1 alloc_tag", 64'(alloc_tag), 64'd0);
      chk("R1 mem_wr_valid", 64'(mem_wr_valid), 64'd0);
      chk("R1 ld_fwd", 64'(ld_fwd), 64'd0);
      chk("R1 ld_unk", 64'(ld_unk), 64'd0);

      // Five stores, fields filled out of order
      for (int s = 0; s < 5; s++) do_alloc();
      chk("R2 tag after five", 64'(alloc_tag), 64'd5);
      put_data(3'd4 - 3'd2, 32'hC2);
      put_addr(3'd2, 16'h0100);
      put_addr(3'd0, 16'h0100);
      put_data(3'd0, 32'hA0);
      put_data(3'd3, 32'hD3);
      put_addr(3'd1, 16'h0200);
      put_data(3'd1, 32'hB1);
      put_addr(3'd4, 16'h0300);

      foreach (LD_TAB[i]) begin
         look($sformatf("R7/R8/R9/R10 row%0d", i), LD_TAB[i].a, LD_TAB[i].tag,
              LD_TAB[i].fwd, LD_TAB[i].unk, LD_TAB[i].d);
      end

      // R11: writes to free entry 6 are dropped
      put_addr(3'd6, 16'h0100);
      put_data(3'd6, 32'hEE);
      put_cmt(3'd6);
      do_alloc();
      do_alloc();
      look("R11 stale entry", 16'h0100, 4'd7, 1'b0, 1'b1, 32'h0);

      // R4/R5/R6: younger complete entry waits for the head
      put_cmt(3'd1);
      @(negedge clk);
      chk("R4 head not committed", 64'(mem_wr_valid), 64'd0);
      put_cmt(3'd0);
      @(negedge clk);
      chk("R4 head ready", 64'(mem_wr_valid), 64'd1);
      chk("R5 head addr", 64'(mem_wr_addr), 64'h100);
      chk("R5 head data", 64'(mem_wr_data), 64'hA0);
      @(negedge clk);
      chk("R6 held while stalled", 64'(mem_wr_data), 64'hA0);
      pulse_ready();
      chk("R5 next in order valid", 64'(mem_wr_valid), 64'd1);
      chk("R5 next in order addr", 64'(mem_wr_addr), 64'h200);
      chk("R5 next in order data", 64'(mem_wr_data), 64'hB1);

      // R3: fill to DEPTH across the wrap
      do_alloc();
      do_alloc();
      chk("R3 full", 64'(alloc_ok), 64'd0);
      chk("R3 tag at full", 64'(alloc_tag), 64'd9);
      do_alloc();
      chk("R3 refused request", 64'(alloc_tag), 64'd9);

      // Lookups after the index wrap
      put_addr(3'd0, 16'h0500);
      put_data(3'd0, 32'hE8);
      look("R7 wrapped youngest", 16'h0500, 4'd9, 1'b1, 1'b0, 32'hE8);
      look("R9 wrapped unknown", 16'h0500, 4'd8, 1'b0, 1'b1, 32'h0);
      look("R8 drained store ignored", 16'h0100, 4'd1, 1'b0, 1'b0, 32'h0);

      // R6: freeing the head reopens allocation
      pulse_ready();
      chk("R6 freed slot", 64'(alloc_ok), 64'd1);
      chk("R4 uncommitted head", 64'(mem_wr_valid), 64'd0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule